// File: doc/BRIEF.md
# Multi-Voice Wavetable Audio Synthesizer

The synthesizer makes one signed audio sample per sample tick by mixing several melodic voices and one noise voice. Each melodic voice steps a 16-bit phase accumulator by a 16-bit frequency increment on every tick. The top six phase bits pick one of 64 points in a waveform entry. The wavetable holds 16 entries: a pure sine, a band-limited square family, a band-limited sawtooth family and two noise patterns. Each voice output is scaled by a logarithmic attenuation level. The scaled voices are summed and saturated. The result is held until the next tick.

The noise voice has no accumulator. It reads its table with the video line counter, so its pattern repeats once per frame. At every frame strobe it switches between its two patterns according to the sign of the held mix, which spreads its spectrum.

The held sample also leaves the block as a DAC code. The code is offset binary, so the level has a DC bias, and its bits are reversed to suit a board that wires the converter lines in reverse order.

Top module: `wt_synth`

## Requirements
- R1: Each melodic voice's phase accumulator is 0 after reset. Every cycle with `tick_i` high adds that voice's increment modulo 2^16. Without a tick the accumulator does not change.
- R2: A voice reads the table point given by accumulator bits [15:10]. The sample latched on a tick uses the accumulator value from before that tick's addition.
- R3: Entry 0 is a sine. Point p holds round(127·sin(2πp/64)), which gives 0, 127, 0 and -127 at points 0, 16, 32 and 48.
- R4: Entries 1 to 13 are harmonic sums. Every such entry is 0 at points 0 and 32, and point 64-p is the negative of point p. Even-numbered entries contain only odd harmonics, so point p+32 is the negative of point p.
- R5: A voice contributes floor(s·G/256), where s is the table value. G is 64, 54, 45, 38, 32, 27, 23, 19, 16, 14, 11, 10, 8, 7 and 6 for levels 15 down to 1. Level 15 is therefore a quarter, or 12 dB, and each lower level is about 1.5 dB quieter. Level 0 contributes exactly 0.
- R6: The noise voice reads point `line_i` of entry 14 or entry 15. Its contribution depends only on the line number and the selected pattern, never on how many ticks have passed.
- R7: The noise pattern select is entry 14 after reset. On each `frame_i` strobe it becomes entry 15 if the held sample is negative and entry 14 otherwise.
- R8: `sample_o` is 0 after reset. On a tick it takes the sum of all voice contributions, saturated to [-128, 127]. Between ticks it is held.
- R9: `dac_o` bit i equals bit 7-i of the offset-binary code (sample_o + 128). Sample 0 therefore shows as 8'h01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Sample-tick strobe |
| frame_i | input | 1 | Frame-end strobe |
| line_i | input | 6 | Video line counter, used as the noise table index |
| inc_i | input | NUM_VOICES*16 | Frequency increments, voice v in bits [16v+15:16v] |
| entry_i | input | NUM_VOICES*4 | Wavetable entry per melodic voice |
| level_i | input | NUM_VOICES*4 | Attenuation level per melodic voice |
| noise_level_i | input | 4 | Attenuation level of the noise voice |
| sample_o | output | 8 | Held signed mixed sample |
| dac_o | output | 8 | Offset-binary DAC code, bit-reversed |

## Verification
The bench uses the default of three melodic voices plus the noise voice. Three voices are enough to test symmetry by pairing voices at mirrored phases in one mix. They also show that mixed contributions add, with both positive and negative peaks. With the 6-bit line input the bench can sweep every noise point under both pattern selects.

// File: rtl/wt_synth_pkg.sv
package wt_synth_pkg;
  localparam int SMP_W   = 8;
  localparam int PH_W    = 16;
  localparam int TBL_AW  = 6;
  localparam int TBL_PTS = 1 << TBL_AW;
  localparam int ENT_W   = 4;
  localparam int NUM_ENT = 1 << ENT_W;
  localparam int LVL_W   = 4;
  localparam int GAIN_SH = 8;
  localparam int SMP_MAX = (1 << (SMP_W - 1)) - 1;
  localparam int SMP_MIN = -(1 << (SMP_W - 1));

  typedef logic signed [SMP_W-1:0] smp_t;
  typedef logic [NUM_ENT*TBL_PTS-1:0][SMP_W-1:0] rom_t;

  function automatic int qsine(int r);
    case (r)
      0: return 0;    1: return 12;   2: return 25;   3: return 37;
      4: return 49;   5: return 60;   6: return 71;   7: return 81;
      8: return 90;   9: return 98;   10: return 106; 11: return 112;
      12: return 117; 13: return 122; 14: return 125; 15: return 126;
      default: return 127;
    endcase
  endfunction

  function automatic int sine_pt(int p);
    int q, r;
    q = (p / (TBL_PTS / 4)) % 4;
    r = p % (TBL_PTS / 4);
    case (q)
      0: return qsine(r);
      1: return qsine(TBL_PTS / 4 - r);
      2: return -qsine(r);
      default: return -qsine(TBL_PTS / 4 - r);
    endcase
  endfunction

  // even entries: odd harmonics only; odd entries: every harmonic, halved
  function automatic int harm_pt(int e, int p);
    int s;
    s = 0;
    for (int k = 1; k <= e + 1; k++)
      if (k == 1 || (e % 2) == 1 || (k % 2) == 1)
        s += sine_pt((k * p) % TBL_PTS) / k;
    if ((e % 2) == 1) s = s / 2;
    if (s > SMP_MAX) s = SMP_MAX;
    if (s < -SMP_MAX) s = -SMP_MAX;
    return s;
  endfunction

  function automatic int noise_pt(int sel, int p);
    int x;
    x = (sel != 0) ? ((p * 61 + 200) ^ (p >> 1)) : ((p * 109 + 37) ^ (p << 3));
    x = x & 255;
    if (x >= 128) x = x - 256;
    if (x < -SMP_MAX) x = -SMP_MAX;
    return x;
  endfunction

  function automatic rom_t build_rom();
    rom_t r;
    for (int e = 0; e < NUM_ENT; e++)
      for (int p = 0; p < TBL_PTS; p++)
        r[e*TBL_PTS+p] = SMP_W'((e >= NUM_ENT - 2) ? noise_pt(e - (NUM_ENT - 2), p)
                                                   : harm_pt(e, p));
    return r;
  endfunction

  // Q8 gains, 1.5 dB per level below level 15 (= 1/4)
  function automatic int gain_q8(logic [LVL_W-1:0] l);
    case (l)
      4'd15: return 64; 4'd14: return 54; 4'd13: return 45; 4'd12: return 38;
      4'd11: return 32; 4'd10: return 27; 4'd9:  return 23; 4'd8:  return 19;
      4'd7:  return 16; 4'd6:  return 14; 4'd5:  return 11; 4'd4:  return 10;
      4'd3:  return 8;  4'd2:  return 7;  4'd1:  return 6;  default: return 0;
    endcase
  endfunction

  function automatic smp_t atten(smp_t s, logic [LVL_W-1:0] l);
    int p;
    p = int'(s) * gain_q8(l);
    return smp_t'(p >>> GAIN_SH);
  endfunction
endpackage

// File: rtl/wt_voice.sv
module wt_voice
  import wt_synth_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic [PH_W-1:0]  inc_i,
  input  logic [ENT_W-1:0] entry_i,
  input  logic [LVL_W-1:0] level_i,
  output smp_t             voice_o
);
  localparam rom_t ROM = build_rom();

  logic [PH_W-1:0]   acc_q;
  logic [TBL_AW-1:0] idx;
  smp_t              raw;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)     acc_q <= '0;
    else if (tick_i) acc_q <= acc_q + inc_i;

  assign idx     = acc_q[PH_W-1 -: TBL_AW];
  assign raw     = smp_t'(ROM[{entry_i, idx}]);
  assign voice_o = atten(raw, level_i);

  a_r1_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(acc_q));
  a_r1_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i |=> acc_q == PH_W'($past(acc_q) + $past(inc_i)));
  a_r5_mute: assert property (@(posedge clk_i) disable iff (!rst_ni)
    level_i == '0 |-> voice_o == '0);
endmodule

// File: rtl/wt_noise.sv
module wt_noise
  import wt_synth_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              frame_i,
  input  logic              mix_sign_i,
  input  logic [TBL_AW-1:0] line_i,
  input  logic [LVL_W-1:0]  level_i,
  output smp_t              noise_o
);
  localparam rom_t ROM = build_rom();
  localparam logic [ENT_W-2:0] NOISE_BASE = '1;

  logic sel_q;
  smp_t raw;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)      sel_q <= 1'b0;
    else if (frame_i) sel_q <= mix_sign_i;

  assign raw     = smp_t'(ROM[{NOISE_BASE, sel_q, line_i}]);
  assign noise_o = atten(raw, level_i);

  a_r7_sel: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_i |=> sel_q == $past(mix_sign_i));
  a_r7_keep: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_i |=> $stable(sel_q));
endmodule

// File: rtl/wt_mix.sv
module wt_mix
  import wt_synth_pkg::*;
#(
  parameter int NUM_IN = 4
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         tick_i,
  input  logic [NUM_IN-1:0][SMP_W-1:0] parts_i,
  output smp_t                         sample_o,
  output logic [SMP_W-1:0]             dac_o
);
  smp_t             sum_sat;
  smp_t             sample_q;
  logic [SMP_W-1:0] offs;

  always_comb begin
    int acc;
    acc = 0;
    for (int i = 0; i < NUM_IN; i++) acc += int'(smp_t'(parts_i[i]));
    if (acc > SMP_MAX)      sum_sat = smp_t'(SMP_MAX);
    else if (acc < SMP_MIN) sum_sat = smp_t'(SMP_MIN);
    else                    sum_sat = smp_t'(acc);
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)     sample_q <= '0;
    else if (tick_i) sample_q <= sum_sat;

  assign offs = {~sample_q[SMP_W-1], sample_q[SMP_W-2:0]};

  for (genvar i = 0; i < SMP_W; i++) begin : g_rev
    assign dac_o[i] = offs[SMP_W-1-i];
  end

  assign sample_o = sample_q;

  a_r8_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(sample_o));
endmodule

// File: rtl/wt_synth.sv
module wt_synth
  import wt_synth_pkg::*;
#(
  parameter int NUM_VOICES = 3
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        tick_i,
  input  logic                        frame_i,
  input  logic [TBL_AW-1:0]           line_i,
  input  logic [NUM_VOICES*PH_W-1:0]  inc_i,
  input  logic [NUM_VOICES*ENT_W-1:0] entry_i,
  input  logic [NUM_VOICES*LVL_W-1:0] level_i,
  input  logic [LVL_W-1:0]            noise_level_i,
  output logic [SMP_W-1:0]            sample_o,
  output logic [SMP_W-1:0]            dac_o
);
  localparam int NUM_IN = NUM_VOICES + 1;

  logic [NUM_IN-1:0][SMP_W-1:0] parts;
  smp_t                         mix;

  for (genvar g = 0; g < NUM_VOICES; g++) begin : g_voice
    smp_t v_out;
    wt_voice u_voice (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .tick_i  (tick_i),
      .inc_i   (inc_i[g*PH_W +: PH_W]),
      .entry_i (entry_i[g*ENT_W +: ENT_W]),
      .level_i (level_i[g*LVL_W +: LVL_W]),
      .voice_o (v_out)
    );
    assign parts[g] = v_out;
  end

  smp_t n_out;
  wt_noise u_noise (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .frame_i    (frame_i),
    .mix_sign_i (mix[SMP_W-1]),
    .line_i     (line_i),
    .level_i    (noise_level_i),
    .noise_o    (n_out)
  );
  assign parts[NUM_VOICES] = n_out;

  wt_mix #(.NUM_IN(NUM_IN)) u_mix (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick_i),
    .parts_i  (parts),
    .sample_o (mix),
    .dac_o    (dac_o)
  );

  assign sample_o = mix;
endmodule

// File: tb/wt_synth_bench.sv
`timescale 1ns/1ps
module wt_synth_bench;
  localparam int NV = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic frame = 1'b0;
  logic [5:0] line = '0;
  logic [NV*16-1:0] inc = '0;
  logic [NV*4-1:0] ent = '0;
  logic [NV*4-1:0] lvl = '0;
  logic [3:0] nlvl = '0;
  logic [7:0] sample;
  logic [7:0] dac;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  wt_synth #(.NUM_VOICES(NV)) u_wt_synth (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .frame_i(frame), .line_i(line),
    .inc_i(inc), .entry_i(ent), .level_i(lvl), .noise_level_i(nlvl),
    .sample_o(sample), .dac_o(dac)
  );

  function automatic int smp();
    return int'($signed(sample));
  endfunction

  function automatic int bsine(int p);
    real x;
    x = 127.0 * $sin(2.0 * 3.14159265358979 * p / 64.0);
    return (x >= 0.0) ? $rtoi(x + 0.5) : -$rtoi(-x + 0.5);
  endfunction

  function automatic int bgain(int l);
    int g[16] = '{0, 6, 7, 8, 10, 11, 14, 16, 19, 23, 27, 32, 38, 45, 54, 64};
    return g[l];
  endfunction

  function automatic int bfloor(int s, int l);
    int p;
    p = s * bgain(l);
    return (p >= 0) ? p / 256 : -((-p + 255) / 256);
  endfunction

  function automatic logic [7:0] bdac(int s);
    logic [7:0] ob, r;
    ob = 8'(s + 128);
    for (int i = 0; i < 8; i++) r[i] = ob[7 - i];
    return r;
  endfunction

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk) rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic do_tick();
    @(negedge clk) tick = 1'b1;
    @(negedge clk) tick = 1'b0;
  endtask

  task automatic do_frame();
    @(negedge clk) frame = 1'b1;
    @(negedge clk) frame = 1'b0;
  endtask

  task automatic set_voice(int v, int i, int e, int l);
    inc[v*16 +: 16] = 16'(i);
    ent[v*4 +: 4]   = 4'(e);
    lvl[v*4 +: 4]   = 4'(l);
  endtask

  task automatic mute_all();
    for (int v = 0; v < NV; v++) set_voice(v, 0, 0, 0);
    nlvl = '0;
  endtask

  task automatic t_reset();
    mute_all();
    do_reset();
    @(negedge clk);
    chk("R8 reset sample", smp(), 0);
    chk("R9 reset dac", int'(dac), 8'h01);
  endtask

  task automatic t_sine_quarter();
    int exp[4] = '{0, 31, 0, -32};
    mute_all();
    set_voice(0, 16'h4000, 0, 15);
    do_reset();
    for (int k = 0; k < 4; k++) begin
      do_tick();
      chk("R3 sine point (R2 pre-add phase)", smp(), exp[k]);
      chk("R9 dac code", int'(dac), int'(bdac(exp[k])));
    end
    repeat (5) @(negedge clk);
    chk("R8 held without tick", smp(), -32);
    do_tick();
    chk("R1 no advance without tick", smp(), 0);
  endtask

  task automatic t_wrap();
    int acc;
    mute_all();
    set_voice(0, 16'h3FFF, 0, 15);
    do_reset();
    acc = 0;
    for (int k = 0; k < 6; k++) begin
      do_tick();
      chk("R2 upper phase bits", smp(), bfloor(bsine((acc >> 10) & 63), 15));
      acc = (acc + 16'h3FFF) & 16'hFFFF;
    end
    set_voice(0, 16'hC000, 0, 15);
    do_reset();
    acc = 0;
    for (int k = 0; k < 5; k++) begin
      do_tick();
      chk("R1 modulo wrap", smp(), bfloor(bsine((acc >> 10) & 63), 15));
      acc = (acc + 16'hC000) & 16'hFFFF;
    end
  endtask

  task automatic t_levels();
    for (int l = 0; l < 16; l++) begin
      mute_all();
      set_voice(1, 16'h4000, 0, l);
      do_reset();
      do_tick();
      do_tick();
      chk("R5 level positive peak", smp(), bfloor(127, l));
      do_tick();
      do_tick();
      chk("R5 level negative peak", smp(), bfloor(-127, l));
    end
  endtask

  task automatic t_mix();
    mute_all();
    set_voice(0, 16'h4000, 0, 15);
    set_voice(1, 16'h4000, 0, 15);
    set_voice(2, 16'hC000, 0, 15);
    do_reset();
    do_tick();
    do_tick();
    chk("R8 mixed sum", smp(), 31 + 31 - 32);
    set_voice(2, 16'h4000, 0, 15);
    do_reset();
    do_tick();
    do_tick();
    chk("R8 three positive", smp(), 93);
    do_tick();
    do_tick();
    chk("R8 three negative", smp(), -96);
    chk("R9 negative dac", int'(dac), int'(bdac(-96)));
  endtask

  task automatic t_sym();
    int pts[3] = '{3, 7, 13};
    for (int e = 1; e < 14; e++) begin
      mute_all();
      set_voice(0, 32 << 10, e, 15);
      do_reset();
      do_tick();
      chk("R4 point zero", smp(), 0);
      do_tick();
      chk("R4 point 32", smp(), 0);
      for (int j = 0; j < 3; j++) begin
        mute_all();
        set_voice(0, pts[j] << 10, e, 15);
        set_voice(1, (64 - pts[j]) << 10, e, 15);
        do_reset();
        do_tick();
        do_tick();
        chk("R4 odd symmetry", int'(smp() == 0 || smp() == -1), 1);
        if (e % 2 == 0) begin
          set_voice(1, (pts[j] + 32) << 10, e, 15);
          do_reset();
          do_tick();
          do_tick();
          chk("R4 half-wave symmetry", int'(smp() == 0 || smp() == -1), 1);
        end
      end
    end
  endtask

  task automatic t_noise();
    int a[64];
    int b;
    int diff;
    mute_all();
    nlvl = 4'd15;
    do_reset();
    for (int l = 0; l < 64; l++) begin
      line = 6'(l);
      do_tick();
      a[l] = smp();
      do_tick();
      chk("R6 same line same value", smp(), a[l]);
    end
    // make the held sample negative, then strobe frame
    nlvl = '0;
    set_voice(0, 16'hC000, 0, 15);
    do_tick();
    do_tick();
    chk("R7 setup negative", smp(), -32);
    do_frame();
    set_voice(0, 16'hC000, 0, 0);
    nlvl = 4'd15;
    diff = 0;
    for (int l = 0; l < 64; l++) begin
      line = 6'(l);
      do_tick();
      if (smp() != a[l]) diff++;
    end
    chk("R7 negative sign selects other pattern", int'(diff > 0), 1);
    nlvl = '0;
    set_voice(0, 16'hC000, 0, 15);
    do_tick();
    do_tick();
    chk("R7 setup positive", smp(), 31);
    do_frame();
    set_voice(0, 0, 0, 0);
    nlvl = 4'd15;
    for (int l = 0; l < 64; l += 9) begin
      line = 6'(l);
      do_tick();
      b = smp();
      chk("R7 positive sign restores first pattern", b, a[l]);
    end
  endtask

  initial begin
    t_reset();
    t_sine_quarter();
    t_wrap();
    t_levels();
    t_mix();
    t_sym();
    t_noise();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule